// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block gathers eight interrupt request lines and presents one interrupt output to a processor. It keeps three eight-bit registers: pending requests, the mask and the in-service set. Priority is fixed, with input 0 highest. When the processor acknowledges, the block returns an eight-bit vector. The upper five bits of the vector are a programmed base and the low three bits are the number of the winning input.

A host writes nine-bit commands through a register port: eight data bits plus an address bit. After reset the block waits for an initialization sequence. The first word of that sequence chooses edge or level triggering. It also says whether the cascade word and the mode word follow. The second word sets the vector base. Once the sequence is complete, address-1 accesses reach the mask register. Address-0 writes choose which register address-0 reads return, or retire the highest-priority in-service request. A mode bit can make the acknowledge retire the request by itself.

Top module: `pic8_ctrl`

## Requirements
- R1: After reset intr_o is low, pending and in-service registers are zero, the mask reads 0x00 and the block waits for a start word. Address-1 writes and interrupt inputs raise no interrupt until the sequence completes.
- R2: A write at a0=0 with data bit 4 set is a start word at any time. It takes the trigger mode from bit 3 (1 = level), the single flag from bit 1 and the mode-word flag from bit 0. It clears mask, pending and in-service registers, selects the pending register for address-0 reads, and turns automatic retirement off.
- R3: After a start word, the next a0=1 write is the base word. A cascade word follows only when the single flag is 0. A mode word follows only when the mode-word flag is 1. The block enters operation after the last expected word. A non-start a0=0 write during the sequence is ignored, and intr_o stays low until operation.
- R4: An acknowledge that finds a request updates vec_o on the same clock edge to {base word bits 7:3, input number}.
- R5: In operation an a0=1 write loads the mask. An a0=1 read returns it. Masked inputs raise no interrupt but still appear in the pending register.
- R6: An a0=0 write with bit 7=0, bit 4=0 and bit 3=1 is a read-select command. If bit 1 is 1, bit 0 selects in-service (1) or pending (0) for later a0=0 reads. If bit 1 is 0, the selection is kept. rdata_o is loaded on the clock edge where rd_i is high.
- R7: intr_o is high in operation when some unmasked pending input has a lower number than every in-service input.
- R8: An acknowledge moves the winning input to the in-service register and, in edge mode, clears its pending bit. An acknowledge with no winner returns {base, 3'b111} and changes no register.
- R9: Writing 0x20 at a0=0 in operation clears the lowest-numbered set bit of the in-service register.
- R10: When mode word bit 1 is set, an acknowledge leaves the in-service register unchanged.
- R11: In edge mode a rising input edge sets its pending bit, and an input held high does not set it again. In level mode the pending register copies the inputs one cycle later, and an acknowledge does not clear it.
- R12: When an acknowledge and a 0x20 retire command arrive in the same cycle, both take effect on the prior in-service contents. A rising edge on the acknowledged input in that cycle leaves its pending bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a0_i | input | 1 | Register address bit |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe, one cycle per command |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data, registered |
| irq_i | input | 8 | Interrupt request inputs |
| intr_o | output | 1 | Interrupt to processor |
| inta_i | input | 1 | Acknowledge strobe, one cycle |
| vec_o | output | 8 | Vector from the last acknowledge |

## Verification
The acknowledge and the retire command both rewrite the in-service register, and they can land on the same clock edge. The bench issues both strobes in one cycle while one input is in service and a higher one is pending. It then expects the new input to be in service and the old one gone. A second collision is between an acknowledge that clears a pending bit in edge mode and a fresh rising edge on that same input in the same cycle. The bench times the edge to the acknowledge and expects the pending bit, read back through the pending register, to remain set.

// File: rtl/pic8_pkg.sv
package pic8_pkg;
  localparam int DATA_W = 8;
  localparam int N_IRQ  = 8;
  localparam int IDX_W  = $clog2(N_IRQ);
  localparam int BASE_W = DATA_W - IDX_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BASE,
    ST_CASC,
    ST_MODE,
    ST_RUN
  } init_st_e;
endpackage

// File: rtl/pic8_cmd.sv
module pic8_cmd
  import pic8_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              a0_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              run_o,
  output logic              ltim_o,
  output logic              aeoi_o,
  output logic [BASE_W-1:0] base_o,
  output logic              start_o,
  output logic              imr_we_o,
  output logic              eoi_o,
  output logic              rsel_we_o,
  output logic              rsel_val_o
);
  init_st_e          st_q;
  logic              single_q, need_mode_q, ltim_q, aeoi_q;
  logic [BASE_W-1:0] base_q;
  logic              op_wr0;

  assign start_o = wr_i & ~a0_i & wdata_i[4];
  assign run_o   = (st_q == ST_RUN);
  assign op_wr0  = wr_i & ~a0_i & ~wdata_i[4] & run_o;

  assign imr_we_o   = wr_i & a0_i & run_o;
  assign rsel_we_o  = op_wr0 & wdata_i[3] & ~wdata_i[7] & wdata_i[1];
  assign rsel_val_o = wdata_i[0];
  assign eoi_o      = run_o & wr_i & ~a0_i & (wdata_i == 8'h20);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      single_q    <= 1'b0;
      need_mode_q <= 1'b0;
      ltim_q      <= 1'b0;
      aeoi_q      <= 1'b0;
      base_q      <= '0;
    end else if (start_o) begin
      st_q        <= ST_BASE;
      ltim_q      <= wdata_i[3];
      single_q    <= wdata_i[1];
      need_mode_q <= wdata_i[0];
      aeoi_q      <= 1'b0;
    end else if (wr_i && a0_i) begin
      unique case (st_q)
        ST_BASE: begin
          base_q <= wdata_i[DATA_W-1:IDX_W];
          if (!single_q)        st_q <= ST_CASC;
          else if (need_mode_q) st_q <= ST_MODE;
          else                  st_q <= ST_RUN;
        end
        ST_CASC: st_q <= need_mode_q ? ST_MODE : ST_RUN;
        ST_MODE: begin
          aeoi_q <= wdata_i[1];
          st_q   <= ST_RUN;
        end
        default: st_q <= st_q;
      endcase
    end
  end

  assign ltim_o = ltim_q;
  assign aeoi_o = aeoi_q;
  assign base_o = base_q;
endmodule

// File: rtl/pic8_irr.sv
module pic8_irr
  import pic8_pkg::*;
#(
  parameter int NIRQ = N_IRQ
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NIRQ-1:0] irq_i,
  input  logic            ltim_i,
  input  logic            clr_all_i,
  input  logic [NIRQ-1:0] ack_clr_i,
  output logic [NIRQ-1:0] irr_o
);
  for (genvar g = 0; g < NIRQ; g++) begin : g_bit
    logic prev_q, irr_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q <= 1'b0;
        irr_q  <= 1'b0;
      end else begin
        prev_q <= irq_i[g];
        if (clr_all_i)   irr_q <= 1'b0;
        else if (ltim_i) irr_q <= irq_i[g];
        // a fresh edge wins over the acknowledge clear
        else             irr_q <= (irr_q & ~ack_clr_i[g]) | (irq_i[g] & ~prev_q);
      end
    end
    assign irr_o[g] = irr_q;
  end
endmodule

// File: rtl/pic8_prio.sv
module pic8_prio
  import pic8_pkg::*;
#(
  parameter int NIRQ = N_IRQ,
  localparam int IW  = $clog2(NIRQ)
) (
  input  logic [NIRQ-1:0] irr_i,
  input  logic [NIRQ-1:0] imr_i,
  input  logic [NIRQ-1:0] isr_i,
  output logic            intr_o,
  output logic [IW-1:0]   req_idx_o,
  output logic [NIRQ-1:0] isr_lo_oh_o
);
  logic [NIRQ-1:0] pend;
  logic            req_vld, isr_vld;
  logic [IW-1:0]   isr_idx;

  assign pend = irr_i & ~imr_i;

  always_comb begin
    req_vld   = 1'b0;
    req_idx_o = '0;
    isr_vld   = 1'b0;
    isr_idx   = '0;
    for (int i = NIRQ - 1; i >= 0; i--) begin
      if (pend[i]) begin
        req_vld   = 1'b1;
        req_idx_o = IW'(i);
      end
      if (isr_i[i]) begin
        isr_vld = 1'b1;
        isr_idx = IW'(i);
      end
    end
  end

  assign isr_lo_oh_o = isr_i & (~isr_i + 1'b1);
  assign intr_o      = req_vld & (~isr_vld | (req_idx_o < isr_idx));
endmodule

// File: rtl/pic8_ctrl.sv
module pic8_ctrl
  import pic8_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a0_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_IRQ-1:0]  irq_i,
  output logic              intr_o,
  input  logic              inta_i,
  output logic [DATA_W-1:0] vec_o
);
  logic              run, ltim, aeoi, start, imr_we, eoi, rsel_we, rsel_val;
  logic [BASE_W-1:0] base;
  logic [N_IRQ-1:0]  irr, imr_q, isr_q, isr_lo_oh, ack_oh;
  logic [IDX_W-1:0]  req_idx;
  logic              intr_raw, ack, ack_take, rsel_q;

  pic8_cmd u_cmd (
    .clk_i, .rst_ni, .wr_i, .a0_i, .wdata_i,
    .run_o(run), .ltim_o(ltim), .aeoi_o(aeoi), .base_o(base),
    .start_o(start), .imr_we_o(imr_we), .eoi_o(eoi),
    .rsel_we_o(rsel_we), .rsel_val_o(rsel_val)
  );

  pic8_irr #(.NIRQ(N_IRQ)) u_irr (
    .clk_i, .rst_ni, .irq_i, .ltim_i(ltim), .clr_all_i(start),
    .ack_clr_i(ack_oh), .irr_o(irr)
  );

  pic8_prio #(.NIRQ(N_IRQ)) u_prio (
    .irr_i(irr), .imr_i(imr_q), .isr_i(isr_q),
    .intr_o(intr_raw), .req_idx_o(req_idx), .isr_lo_oh_o(isr_lo_oh)
  );

  assign intr_o   = run & intr_raw;
  assign ack      = inta_i & run;
  assign ack_take = ack & intr_raw;
  assign ack_oh   = ack_take ? (N_IRQ'(1) << req_idx) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      imr_q  <= '0;
      isr_q  <= '0;
      rsel_q <= 1'b0;
    end else if (start) begin
      imr_q  <= '0;
      isr_q  <= '0;
      rsel_q <= 1'b0;
    end else begin
      if (imr_we)  imr_q  <= wdata_i;
      if (rsel_we) rsel_q <= rsel_val;
      // retire and acknowledge both act on the prior in-service set
      isr_q <= (isr_q & ~(eoi ? isr_lo_oh : '0)) | (aeoi ? '0 : ack_oh);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      vec_o   <= '0;
    end else begin
      if (rd_i) rdata_o <= a0_i ? imr_q : (rsel_q ? isr_q : irr);
      if (ack)  vec_o   <= ack_take ? {base, req_idx} : {base, {IDX_W{1'b1}}};
    end
  end
endmodule

// File: rtl/pic8_chk.sv
module pic8_chk
  import pic8_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic              inta_i,
  input logic              intr_o,
  input logic              run,
  input logic              aeoi,
  input logic              ltim,
  input logic              eoi,
  input logic [BASE_W-1:0] base,
  input logic [N_IRQ-1:0]  isr,
  input logic [N_IRQ-1:0]  irr,
  input logic [N_IRQ-1:0]  irq_i,
  input logic [DATA_W-1:0] vec_o
);
  AST_NO_INTR_IN_INIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> !intr_o); // R3

  AST_VEC_HAS_BASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inta_i && run |=> vec_o[DATA_W-1:IDX_W] == $past(base)); // R4

  AST_ACK_ADDS_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inta_i && intr_o && !aeoi && !wr_i |=> $countones(isr) == $past($countones(isr)) + 1); // R8

  AST_EOI_DROPS_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi && !inta_i && isr != '0 |=> $countones(isr) == $past($countones(isr)) - 1); // R9

  AST_AUTO_KEEPS_ISR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aeoi && !wr_i |=> $stable(isr)); // R10

  AST_LEVEL_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ltim && !wr_i |=> irr == $past(irq_i)); // R11
endmodule

bind pic8_ctrl pic8_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .inta_i(inta_i),
  .intr_o(intr_o), .run(run), .aeoi(aeoi), .ltim(ltim), .eoi(eoi),
  .base(base), .isr(isr_q), .irr(irr), .irq_i(irq_i), .vec_o(vec_o)
);

// File: tb/pic8_ctrl_tb.sv
module pic8_ctrl_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       a0_i = 1'b0, wr_i = 1'b0, rd_i = 1'b0, inta_i = 1'b0;
  logic [7:0] wdata_i = '0, irq_i = '0;
  logic [7:0] rdata_o, vec_o;
  logic       intr_o;
  int         n_chk = 0, n_err = 0;

  always #2 clk_i = ~clk_i;

  pic8_ctrl u_dut (
    .clk_i, .rst_ni, .a0_i, .wdata_i, .wr_i, .rd_i, .rdata_o,
    .irq_i, .intr_o, .inta_i, .vec_o
  );

  // {irq pattern, mask, expect intr, expect vector}; base 0x90, edge mode
  localparam logic [24:0] VEC_TBL [6] = '{
    {8'h01, 8'h00, 1'b1, 8'h90},
    {8'h80, 8'h00, 1'b1, 8'h97},
    {8'h6C, 8'h00, 1'b1, 8'h92},
    {8'hF0, 8'h30, 1'b1, 8'h96},
    {8'h0F, 8'h0F, 1'b0, 8'h00},
    {8'h12, 8'h02, 1'b1, 8'h94}
  };

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(logic a, logic [7:0] d);
    a0_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd(logic a, output logic [7:0] v);
    a0_i = a; rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
    v = rdata_o;
  endtask

  task automatic ack(output logic [7:0] v);
    inta_i = 1'b1;
    @(negedge clk_i);
    inta_i = 1'b0;
    v = vec_o;
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk_i);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    tick(3);
    rst_ni = 1'b1;
    tick();

    // reset state and pre-init behaviour
    chk("R1 intr after reset", {7'b0, intr_o}, 8'h00);
    rd(1'b1, v); chk("R1 mask after reset", v, 8'h00);
    rd(1'b0, v); chk("R1 pending after reset", v, 8'h00);
    wr(1'b1, 8'h55);
    rd(1'b1, v); chk("R1 mask write ignored before init", v, 8'h00);
    irq_i = 8'hFF; tick(2);
    chk("R1 no intr before init", {7'b0, intr_o}, 8'h00);
    irq_i = 8'h00; tick();

    // vector table walk
    for (int i = 0; i < 6; i++) begin
      logic [24:0] e;
      e = VEC_TBL[i];
      irq_i = 8'h00;
      wr(1'b0, 8'h13); wr(1'b1, 8'h90); wr(1'b1, 8'h01);
      wr(1'b1, e[16:9]);
      irq_i = e[24:17]; tick();
      chk("R7 intr for pattern", {7'b0, intr_o}, {7'b0, e[8]});
      wr(1'b0, 8'h0A);
      rd(1'b0, v); chk("R5 masked inputs still pending", v, e[24:17]);
      if (e[8]) begin
        ack(v); chk("R4 vector for pattern", v, e[7:0]);
      end
    end
    irq_i = 8'h00; tick();

    // cascade word and mode word present, automatic retirement
    wr(1'b0, 8'h11);
    irq_i = 8'h08;
    wr(1'b1, 8'h20);
    wr(1'b1, 8'h04);
    chk("R3 no intr before mode word", {7'b0, intr_o}, 8'h00);
    wr(1'b1, 8'h03);
    chk("R3 intr once running", {7'b0, intr_o}, 8'h01);
    ack(v); chk("R4 vector base 0x20 input 3", v, 8'h23);
    wr(1'b0, 8'h0B);
    rd(1'b0, v); chk("R10 auto retire leaves ISR empty", v, 8'h00);
    wr(1'b0, 8'h0A);
    rd(1'b0, v); chk("R8 edge pending cleared by ack", v, 8'h00);
    chk("R11 held input does not relatch", {7'b0, intr_o}, 8'h00);
    irq_i = 8'h00; tick();

    // single, no mode word: running after base word
    wr(1'b0, 8'h12); wr(1'b1, 8'h48);
    wr(1'b1, 8'hAA);
    rd(1'b1, v); chk("R3 R5 a0=1 after base word is mask", v, 8'hAA);

    // nesting, retire, same-cycle collisions
    wr(1'b0, 8'h13); wr(1'b1, 8'h08); wr(1'b1, 8'h01);
    rd(1'b1, v); chk("R2 start word clears mask", v, 8'h00);
    irq_i = 8'h20; tick();
    chk("R7 intr input 5", {7'b0, intr_o}, 8'h01);
    ack(v); chk("R4 vector input 5", v, 8'h0D);
    wr(1'b0, 8'h0B);
    rd(1'b0, v); chk("R6 ISR select", v, 8'h20);
    wr(1'b0, 8'h08);
    rd(1'b0, v); chk("R6 select kept when RR clear", v, 8'h20);
    irq_i = 8'h60; tick();
    chk("R7 lower priority blocked", {7'b0, intr_o}, 8'h00);
    irq_i = 8'h64; tick();
    chk("R7 higher priority nests", {7'b0, intr_o}, 8'h01);
    ack(v); chk("R4 vector input 2", v, 8'h0A);
    rd(1'b0, v); chk("R8 two in service", v, 8'h24);
    wr(1'b0, 8'h20);
    rd(1'b0, v); chk("R9 retire clears input 2", v, 8'h20);
    chk("R9 input 6 still blocked", {7'b0, intr_o}, 8'h00);
    irq_i = 8'h66; tick();
    a0_i = 1'b0; wdata_i = 8'h20; wr_i = 1'b1; inta_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0; inta_i = 1'b0;
    chk("R12 vector on collision", vec_o, 8'h09);
    rd(1'b0, v); chk("R12 ISR after ack with retire", v, 8'h02);
    chk("R7 input 6 blocked by input 1", {7'b0, intr_o}, 8'h00);
    wr(1'b0, 8'h20);
    chk("R9 input 6 released", {7'b0, intr_o}, 8'h01);
    ack(v); chk("R4 vector input 6", v, 8'h0E);
    wr(1'b0, 8'h20);
    irq_i = 8'h00; tick();
    irq_i = 8'h08; tick();
    irq_i = 8'h00; tick();
    irq_i = 8'h08; inta_i = 1'b1;
    @(negedge clk_i);
    inta_i = 1'b0;
    chk("R12 vector input 3", vec_o, 8'h0B);
    wr(1'b0, 8'h0A);
    rd(1'b0, v); chk("R12 edge in ack cycle stays pending", v, 8'h08);
    chk("R7 equal priority blocked", {7'b0, intr_o}, 8'h00);
    irq_i = 8'h00; tick();

    // level mode and empty acknowledge
    wr(1'b0, 8'h1B); wr(1'b1, 8'h50); wr(1'b1, 8'h01);
    irq_i = 8'h10; tick();
    chk("R11 level request raises intr", {7'b0, intr_o}, 8'h01);
    ack(v); chk("R4 vector level input 4", v, 8'h54);
    rd(1'b0, v); chk("R11 level pending kept after ack", v, 8'h10);
    chk("R7 blocked while in service", {7'b0, intr_o}, 8'h00);
    wr(1'b0, 8'h20);
    chk("R11 level request reasserts", {7'b0, intr_o}, 8'h01);
    irq_i = 8'h00; tick();
    chk("R11 level request withdrawn", {7'b0, intr_o}, 8'h00);
    ack(v); chk("R8 empty ack vector", v, 8'h57);
    wr(1'b0, 8'h0B);
    rd(1'b0, v); chk("R8 empty ack leaves ISR", v, 8'h00);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule